// File: doc/BRIEF.md
# Multi-Group Lockstep PWM Generator

This block produces pulse-width-modulated outputs for several independent groups. Each group has four channels, one period counter, one active period, one active mode and four active duty values. A group counts either as a sawtooth (edge-aligned) or as an up/down triangle (center-aligned). It can reload its duty values at the start of each period only, or at both the start and the midpoint. Software writes go into shadow copies, and a group moves them into its active set only at those update points. Each channel's output therefore never changes configuration in the middle of a segment.

A group has two run controls: an output-enable bit and a counter-only enable bit. Either one keeps the counter running. Only the output-enable bit lets the channels drive high. Software can therefore set the counter-only bits of several groups in one write, so that those counters start on the same clock edge, and then turn the outputs on later without disturbing the alignment. A counter halts only after both of its bits have been cleared.

Every period start sets a per-group status flag. Software clears a flag by writing 1 to it. A per-group mask selects which flags reach the single interrupt line.

Top module: `pwm_sync_top`

## Requirements
- R1: Edge-aligned mode (mode bit 0 = 0): the counter steps 0,1,…,P-1 and restarts, so a period lasts P cycles. A channel is high while counter < duty.
- R2: Center-aligned mode (mode bit 0 = 1): the counter rises from 0 to H-1, holds at H-1 for one cycle while turning, then falls to 0, with H = P>>1. A period lasts 2·max(H,1) cycles, and a channel is high while 2·counter + duty ≥ P.
- R3: A duty of 0 keeps a channel low for the whole period. A duty ≥ P keeps it high for the whole period.
- R4: Writes to period, mode and duty registers (group g at address 8·(g+1): +0 mode, +1 period, +2..+5 duty of channels 0..3) land in shadow copies. These copies become active only on the edge that starts a period.
- R5: With mode bit 1 = 1 (double update), the duty shadows are also copied at the midpoint. In edge mode that is the edge where the counter reaches P>>1. In center mode it is the edge where the counter turns downward.
- R6: The status bit of a group is set on the same edge on which its counter begins a period. This includes the first period after the counter starts.
- R7: Writing the status register (address 4) clears each bit written as 1 and leaves each bit written as 0 unchanged. A period start on the same edge wins over the clear.
- R8: The interrupt output is high exactly when some status bit is set whose bit in the mask register (address 5) is also set.
- R9: Setting a group's counter-only bit (address 2, write 1 to set; address 3, write 1 to clear) runs the counter while that group's outputs stay low. The outputs follow the compare only while the output-enable bit is set (address 0 sets, address 1 clears).
- R10: A running counter keeps counting while either enable bit is set. It stops and returns to 0 only once both bits are clear.
- R11: Counter-only bits of several groups set in one write start all of those counters on the same edge, so groups with equal settings produce identical outputs.
- R12: Reads return the output-enable bits (addresses 0 and 1), the counter-only bits (2 and 3), status (4), mask (5), and each group's shadow mode, period and duties. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| pwm_o | output | NGRP*NCH | Channel outputs, group g channel c at bit g*NCH+c |
| irq_o | output | 1 | Masked period-start interrupt |

## Verification
The bench targets duties of 0, exactly P and above P. A design with an off-by-one compare would leak a one-cycle pulse at duty 0 or drop one at full duty. It also writes shadows in the middle of a period; a design that copied them at once would show a truncated or stretched pulse in the running period. Double update is exercised in both counting modes, where reloading at the wrong midpoint edge shifts a pulse by one cycle. Further cases cover a status clear that lands on the same edge as a period start (a design where the clear won would lose an interrupt), a counter halted by only one of its two enables, and two groups started in one write, which must stay bit-identical.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
    localparam int unsigned ADR_OEN_SET = 0;
    localparam int unsigned ADR_OEN_CLR = 1;
    localparam int unsigned ADR_SYN_SET = 2;
    localparam int unsigned ADR_SYN_CLR = 3;
    localparam int unsigned ADR_STAT    = 4;
    localparam int unsigned ADR_MASK    = 5;
    localparam int unsigned GRP_SHIFT   = 3;
    localparam int unsigned OFS_MODE    = 0;
    localparam int unsigned OFS_PER     = 1;
    localparam int unsigned OFS_DUTY0   = 2;
    localparam int unsigned MODE_W      = 2;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;
endpackage

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs #(
    parameter int unsigned NGRP   = 2,
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   wr_addr_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    input  logic [ADDR_W-1:0]                   rd_addr_i,
    output logic [DATA_W-1:0]                   rd_data_o,
    input  logic [NGRP-1:0]                     start_i,
    output logic [NGRP-1:0]                     oen_o,
    output logic [NGRP-1:0]                     sen_o,
    output logic [NGRP-1:0]                     stat_o,
    output logic [NGRP-1:0]                     mask_o,
    output logic [NGRP-1:0][1:0]                mode_o,
    output logic [NGRP-1:0][CNT_W-1:0]          per_o,
    output logic [NGRP-1:0][NCH-1:0][CNT_W-1:0] duty_o
);
    import pwm_sync_pkg::*;

    localparam int unsigned GW = ADDR_W - GRP_SHIFT;

    typedef struct packed {
        logic [NGRP-1:0]                     oen;
        logic [NGRP-1:0]                     sen;
        logic [NGRP-1:0]                     stat;
        logic [NGRP-1:0]                     mask;
        logic [NGRP-1:0][1:0]                mode;
        logic [NGRP-1:0][CNT_W-1:0]          per;
        logic [NGRP-1:0][NCH-1:0][CNT_W-1:0] duty;
    } regs_t;

    regs_t q, d;
    logic [NGRP-1:0]  wbits;
    logic [GW-1:0]    wgrp;
    logic [GW-1:0]    rgrp;
    logic [GRP_SHIFT-1:0] woff;
    logic [GRP_SHIFT-1:0] roff;

    assign wbits = wr_data_i[NGRP-1:0];
    assign wgrp  = wr_addr_i[ADDR_W-1:GRP_SHIFT];
    assign woff  = wr_addr_i[GRP_SHIFT-1:0];
    assign rgrp  = rd_addr_i[ADDR_W-1:GRP_SHIFT];
    assign roff  = rd_addr_i[GRP_SHIFT-1:0];

    // next-state: flags set by period starts, then the register write
    always_comb begin
        d      = q;
        d.stat = q.stat | start_i;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADR_OEN_SET)) d.oen = q.oen | wbits;
            if (wr_addr_i == ADDR_W'(ADR_OEN_CLR)) d.oen = q.oen & ~wbits;
            if (wr_addr_i == ADDR_W'(ADR_SYN_SET)) d.sen = q.sen | wbits;
            if (wr_addr_i == ADDR_W'(ADR_SYN_CLR)) d.sen = q.sen & ~wbits;
            if (wr_addr_i == ADDR_W'(ADR_STAT))    d.stat = (q.stat & ~wbits) | start_i;
            if (wr_addr_i == ADDR_W'(ADR_MASK))    d.mask = wbits;
            for (int g = 0; g < NGRP; g++) begin
                if (wgrp == GW'(g + 1)) begin
                    if (woff == GRP_SHIFT'(OFS_MODE)) d.mode[g] = wr_data_i[1:0];
                    if (woff == GRP_SHIFT'(OFS_PER))  d.per[g]  = wr_data_i[CNT_W-1:0];
                    for (int c = 0; c < NCH; c++) begin
                        if (woff == GRP_SHIFT'(OFS_DUTY0 + c))
                            d.duty[g][c] = wr_data_i[CNT_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADR_OEN_SET) || rd_addr_i == ADDR_W'(ADR_OEN_CLR))
            rd_data_o = DATA_W'(q.oen);
        if (rd_addr_i == ADDR_W'(ADR_SYN_SET) || rd_addr_i == ADDR_W'(ADR_SYN_CLR))
            rd_data_o = DATA_W'(q.sen);
        if (rd_addr_i == ADDR_W'(ADR_STAT)) rd_data_o = DATA_W'(q.stat);
        if (rd_addr_i == ADDR_W'(ADR_MASK)) rd_data_o = DATA_W'(q.mask);
        for (int g = 0; g < NGRP; g++) begin
            if (rgrp == GW'(g + 1)) begin
                if (roff == GRP_SHIFT'(OFS_MODE)) rd_data_o = DATA_W'(q.mode[g]);
                if (roff == GRP_SHIFT'(OFS_PER))  rd_data_o = DATA_W'(q.per[g]);
                for (int c = 0; c < NCH; c++) begin
                    if (roff == GRP_SHIFT'(OFS_DUTY0 + c))
                        rd_data_o = DATA_W'(q.duty[g][c]);
                end
            end
        end
    end

    assign oen_o  = q.oen;
    assign sen_o  = q.sen;
    assign stat_o = q.stat;
    assign mask_o = q.mask;
    assign mode_o = q.mode;
    assign per_o  = q.per;
    assign duty_o = q.duty;
endmodule

// File: rtl/pwm_sync_group.sv
module pwm_sync_group #(
    parameter int unsigned NCH   = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      run_i,
    input  logic                      oen_i,
    input  logic [1:0]                mode_i,
    input  logic [CNT_W-1:0]          per_i,
    input  logic [NCH-1:0][CNT_W-1:0] duty_i,
    output logic [NCH-1:0]            pwm_o,
    output logic                      start_o,
    output logic                      running_o
);
    import pwm_sync_pkg::*;

    localparam int unsigned XW = CNT_W + 2;

    typedef struct packed {
        logic                      running;
        dir_e                      dir;
        logic                      ctr;
        logic                      dbl;
        logic [CNT_W-1:0]          cnt;
        logic [CNT_W-1:0]          per;
        logic [NCH-1:0][CNT_W-1:0] duty;
    } grp_t;

    grp_t             q, d;
    logic [CNT_W-1:0] half;
    logic [CNT_W:0]   cnt_inc;
    logic             start, mid;
    logic [NCH-1:0]   hi;

    always_comb begin
        d       = q;
        start   = 1'b0;
        mid     = 1'b0;
        half    = q.per >> 1;
        cnt_inc = {1'b0, q.cnt} + (CNT_W + 1)'(1);
        if (!run_i) begin
            d.running = 1'b0;
            d.cnt     = '0;
            d.dir     = DIR_UP;
        end else if (!q.running) begin
            start = 1'b1;
        end else if (q.ctr) begin
            if (q.dir == DIR_UP) begin
                if (cnt_inc >= {1'b0, half}) begin
                    d.dir = DIR_DN;
                    mid   = q.dbl;
                end else begin
                    d.cnt = cnt_inc[CNT_W-1:0];
                end
            end else if (q.cnt == '0) begin
                start = 1'b1;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end else begin
            if (cnt_inc >= {1'b0, q.per}) begin
                start = 1'b1;
            end else begin
                d.cnt = cnt_inc[CNT_W-1:0];
                mid   = q.dbl && (cnt_inc == {1'b0, half});
            end
        end
        if (start) begin
            d.running = 1'b1;
            d.cnt     = '0;
            d.dir     = DIR_UP;
            d.per     = per_i;
            d.ctr     = mode_i[0];
            d.dbl     = mode_i[1];
            d.duty    = duty_i;
        end
        if (mid) d.duty = duty_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            if (q.ctr)
                hi[c] = ({1'b0, q.cnt, 1'b0} + XW'(q.duty[c])) >= XW'(q.per);
            else
                hi[c] = q.cnt < q.duty[c];
        end
    end

    assign pwm_o     = hi & {NCH{oen_i & q.running}};
    assign start_o   = start;
    assign running_o = q.running;
endmodule

// File: rtl/pwm_sync_top.sv
module pwm_sync_top #(
    parameter int unsigned NGRP   = 2,
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic [NGRP*NCH-1:0]    pwm_o,
    output logic                   irq_o
);
    logic [NGRP-1:0]                     oen, sen, stat, mask, start, running;
    logic [NGRP-1:0][1:0]                mode_sh;
    logic [NGRP-1:0][CNT_W-1:0]          per_sh;
    logic [NGRP-1:0][NCH-1:0][CNT_W-1:0] duty_sh;

    pwm_sync_regs #(
        .NGRP(NGRP), .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .start_i   (start),
        .oen_o     (oen),
        .sen_o     (sen),
        .stat_o    (stat),
        .mask_o    (mask),
        .mode_o    (mode_sh),
        .per_o     (per_sh),
        .duty_o    (duty_sh)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pwm_sync_group #(.NCH(NCH), .CNT_W(CNT_W)) i_grp (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .run_i     (oen[g] | sen[g]),
            .oen_i     (oen[g]),
            .mode_i    (mode_sh[g]),
            .per_i     (per_sh[g]),
            .duty_i    (duty_sh[g]),
            .pwm_o     (pwm_o[g*NCH +: NCH]),
            .start_o   (start[g]),
            .running_o (running[g])
        );
    end

    assign irq_o = |(stat & mask);
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk #(
    parameter int unsigned NGRP = 2,
    parameter int unsigned NCH  = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                irq_o,
    input logic [NGRP*NCH-1:0] pwm_o,
    input logic [NGRP-1:0]     oen,
    input logic [NGRP-1:0]     sen,
    input logic [NGRP-1:0]     stat,
    input logic [NGRP-1:0]     mask,
    input logic [NGRP-1:0]     start,
    input logic [NGRP-1:0]     running
);
    assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == '0) |-> !irq_o);

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        assert_out_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !oen[g] |-> (pwm_o[g*NCH +: NCH] == '0));
        assert_flag_on_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            start[g] |=> stat[g]);
        assert_flag_only_by_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stat[g] && !start[g]) |=> !stat[g]);
        assert_halt_both_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!oen[g] && !sen[g]) |=> !running[g]);
        assert_keep_running_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((oen[g] || sen[g]) && running[g]) |=> running[g]);
    end
endmodule

bind pwm_sync_top pwm_sync_chk #(.NGRP(NGRP), .NCH(NCH)) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_o   (irq_o),
    .pwm_o   (pwm_o),
    .oen     (oen),
    .sen     (sen),
    .stat    (stat),
    .mask    (mask),
    .start   (start),
    .running (running)
);

// File: tb/test_pwm_sync_top.sv
module test_pwm_sync_top;
    localparam int NG = 2;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic [5:0]  rd_addr;
    logic [15:0] rd_data;
    logic [7:0]  pwm;
    logic        irq;

    int n_vec  = 0;
    int n_fail = 0;
    string cur_req = "R12";
    bit done = 0;

    // behavioural reference state
    int m_run[NG], m_cnt[NG], m_dir[NG], m_per[NG], m_ctr[NG], m_dbl[NG];
    int m_duty[NG][NC];
    int s_mode[NG], s_per[NG];
    int s_duty[NG][NC];
    int m_oen = 0, m_sen = 0, m_stat = 0, m_mask = 0;

    always #4 clk = ~clk;

    pwm_sync_top i_pwm_sync_top (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .pwm_o     (pwm),
        .irq_o     (irq)
    );

    initial begin
        for (int g = 0; g < NG; g++) begin
            m_run[g] = 0; m_cnt[g] = 0; m_dir[g] = 0; m_per[g] = 0;
            m_ctr[g] = 0; m_dbl[g] = 0; s_mode[g] = 0; s_per[g] = 0;
            for (int c = 0; c < NC; c++) begin
                m_duty[g][c] = 0; s_duty[g][c] = 0;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) begin
                m_run[g] = 0; m_cnt[g] = 0; m_dir[g] = 0; m_per[g] = 0;
                m_ctr[g] = 0; m_dbl[g] = 0; s_mode[g] = 0; s_per[g] = 0;
                for (int c = 0; c < NC; c++) begin
                    m_duty[g][c] = 0; s_duty[g][c] = 0;
                end
            end
            m_oen = 0; m_sen = 0; m_stat = 0; m_mask = 0;
        end else begin
            int setm;
            setm = 0;
            for (int g = 0; g < NG; g++) begin
                int run, st, md;
                run = ((m_oen | m_sen) >> g) & 1;
                st = 0; md = 0;
                if (run == 0) begin
                    m_run[g] = 0; m_cnt[g] = 0; m_dir[g] = 0;
                end else if (m_run[g] == 0) begin
                    st = 1;
                end else if (m_ctr[g] != 0) begin
                    if (m_dir[g] == 0) begin
                        if (m_cnt[g] + 1 >= m_per[g] / 2) begin
                            m_dir[g] = 1; md = m_dbl[g];
                        end else m_cnt[g]++;
                    end else if (m_cnt[g] == 0) st = 1;
                    else m_cnt[g]--;
                end else begin
                    if (m_cnt[g] + 1 >= m_per[g]) st = 1;
                    else begin
                        m_cnt[g]++;
                        if (m_dbl[g] != 0 && m_cnt[g] == m_per[g] / 2) md = 1;
                    end
                end
                if (st != 0) begin
                    m_run[g] = 1; m_cnt[g] = 0; m_dir[g] = 0;
                    m_per[g] = s_per[g];
                    m_ctr[g] = s_mode[g] & 1;
                    m_dbl[g] = (s_mode[g] >> 1) & 1;
                    setm |= (1 << g);
                end
                if (st != 0 || md != 0)
                    for (int c = 0; c < NC; c++) m_duty[g][c] = s_duty[g][c];
            end
            m_stat |= setm;
            if (wr_en) begin
                int a, v, b;
                a = int'(wr_addr); v = int'(wr_data); b = v & 3;
                case (a)
                    0: m_oen |= b;
                    1: m_oen &= ~b;
                    2: m_sen |= b;
                    3: m_sen &= ~b;
                    4: m_stat = (m_stat & ~b) | setm;
                    5: m_mask = b;
                    default: begin
                        int g, k;
                        g = a / 8 - 1; k = a % 8;
                        if (g >= 0 && g < NG) begin
                            if (k == 0) s_mode[g] = v & 3;
                            else if (k == 1) s_per[g] = v;
                            else if (k >= 2 && k < 2 + NC) s_duty[g][k-2] = v;
                        end
                    end
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_pwm();
        logic [7:0] r;
        r = '0;
        for (int g = 0; g < NG; g++)
            for (int c = 0; c < NC; c++) begin
                bit hi;
                if (m_ctr[g] != 0) hi = (2 * m_cnt[g] + m_duty[g][c]) >= m_per[g];
                else               hi = m_cnt[g] < m_duty[g][c];
                r[g*NC+c] = hi && m_run[g] != 0 && ((m_oen >> g) & 1) != 0;
            end
        return r;
    endfunction

    function automatic logic [15:0] exp_rd(int a);
        int g, k;
        if (a <= 1) return 16'(m_oen);
        if (a <= 3) return 16'(m_sen);
        if (a == 4) return 16'(m_stat);
        if (a == 5) return 16'(m_mask);
        g = a / 8 - 1; k = a % 8;
        if (g < 0 || g >= NG) return '0;
        if (k == 0) return 16'(s_mode[g]);
        if (k == 1) return 16'(s_per[g]);
        if (k >= 2 && k < 2 + NC) return 16'(s_duty[g][k-2]);
        return '0;
    endfunction

    // compare every clock, half a period after the active edge
    always @(negedge clk) begin
        logic [7:0]  ep;
        logic        ei;
        logic [15:0] er;
        if (!done) begin
            ep = exp_pwm();
            ei = (m_stat & m_mask) != 0;
            er = exp_rd(int'(rd_addr));
            n_vec++;
            if (pwm !== ep) begin
                n_fail++;
                $display("FAIL %s pwm_o act=%h exp=%h t=%0t", cur_req, pwm, ep, $time);
            end
            if (irq !== ei) begin
                n_fail++;
                $display("FAIL %s irq_o act=%b exp=%b t=%0t", cur_req, irq, ei, $time);
            end
            if (rd_data !== er) begin
                n_fail++;
                $display("FAIL %s rd_data_o[%0d] act=%h exp=%h t=%0t", cur_req, rd_addr, rd_data, er, $time);
            end
        end
    end

    task automatic wr(input int a, input int v);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 16'(v); rd_addr = 6'(a);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R12: configure shadows and read the whole map back
        cur_req = "R12";
        wr(8, 0);  wr(9, 10);  wr(10, 0); wr(11, 3); wr(12, 10); wr(13, 12);
        wr(16, 1); wr(17, 12); wr(18, 4); wr(19, 6); wr(20, 0);  wr(21, 20);
        for (int a = 0; a < 32; a++) begin rd_addr = 6'(a); idle(1); end
        rd_addr = 6'd4;
        // R1: edge-aligned sawtooth on group 0
        cur_req = "R1";
        wr(0, 1); idle(35);
        // R3: duty 0 and duty >= period channels over more periods
        cur_req = "R3";
        idle(20);
        // R4: shadow writes mid-period
        cur_req = "R4";
        idle(3); wr(9, 6); wr(11, 5); idle(30);
        // R2: center-aligned group 1, counter-only first, then outputs
        cur_req = "R2";
        wr(2, 2); idle(10); wr(0, 2); idle(40);
        // R5: double update in center and edge modes
        cur_req = "R5";
        wr(16, 3); idle(14); wr(18, 8); idle(5); wr(19, 2); idle(30);
        wr(8, 2); idle(5); wr(11, 1); idle(4); wr(12, 4); idle(20);
        // R9: counter-only run keeps outputs low
        cur_req = "R9";
        wr(1, 3); wr(3, 3); idle(3); wr(2, 1); idle(25); wr(0, 1); idle(15);
        // R10: one enable still set keeps counting; both clear stops
        cur_req = "R10";
        wr(1, 1); idle(10); wr(0, 1); wr(3, 1); idle(10); wr(1, 1); idle(10);
        wr(1, 3); wr(3, 3); idle(3);
        // R11: lockstep start of both groups with equal settings
        cur_req = "R11";
        wr(8, 2);  wr(9, 6);  wr(10, 0); wr(11, 5); wr(12, 10); wr(13, 12);
        wr(16, 2); wr(17, 6); wr(18, 0); wr(19, 5); wr(20, 10); wr(21, 12);
        wr(2, 3); idle(4); wr(0, 3);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            n_vec++;
            if (pwm[3:0] !== pwm[7:4]) begin
                n_fail++;
                $display("FAIL R11 group1 act=%h exp=%h", pwm[7:4], pwm[3:0]);
            end
        end
        @(posedge clk); #2;
        // R6: flags follow period starts; short period restarts every cycle
        cur_req = "R6";
        wr(5, 0); wr(4, 3); idle(2); wr(9, 1); idle(12);
        // R8: mask selects which flag reaches the line
        cur_req = "R8";
        wr(5, 1); idle(3); wr(4, 1); wr(4, 2); idle(2); wr(4, 0);
        wr(5, 2); wr(4, 2); idle(4);
        wr(1, 3); wr(3, 3); idle(4);
        // R7: write-one-to-clear, zero leaves the bit alone
        cur_req = "R7";
        wr(5, 3); wr(4, 0); idle(2); wr(4, 1); idle(2); wr(4, 0); wr(4, 2); idle(3);
        wr(5, 0); idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule